// File: doc/BRIEF.md
# Multi-Key Shared-Counter Debouncer

This block cleans up a small group of active-low push-button inputs with one shared debounce timer. Every key input is first brought into the core clock domain by a chain of flops. Any change of a synchronized level counts as an event. The first event opens a debounce window that is timed by a single counter. The counter advances only on cycles where the divided-clock enable `tick_i` is high. When the window runs out without disturbance, the block captures the owning key's level into that key's status bit and raises an interrupt.

Only one key can own the timer at a time:

- Further bounces of the owning key restart the window from zero.
- An event on any other key cancels the window outright. No status bit changes and no interrupt is raised.

While the timer is running, the block forces the supply-enable and clock-enable request flags high, so the debounce clock keeps running. Outside the window, those flags follow the values supplied by the register file. The block only works while `mode_active_i` reports an active operating mode. The interrupt is removed by a status-register read strobe or by an explicit clear command.

Top module: `key_debouncer`

## Requirements
- R1: While `mode_active_i` is 0, key events are ignored. A key change made while the block is inactive does not start a window later, when the block becomes active again.
- R2: A key level change reaches the timer after the synchronizer. With `tick_i` held high, `irq_o` rises WINDOW+3 clock edges after the input changes, and `busy_o` is 1 from the third edge onward.
- R3: The window ends on the WINDOW-th tick after it starts. At that point the owner's status bit is updated, `irq_o` is set and `busy_o` returns to 0.
- R4: Status bit k (bit position k of `status_o` belongs to `key_ni[k]`) becomes 1 when the key is low at expiry and 0 when it is high. All other status bits keep their values.
- R5: A further change of the owning key during a window restarts the count at zero. `busy_o` stays 1, and expiry comes WINDOW ticks after the last change.
- R6: A change of any other key during a window stops the timer. No status bit changes and no interrupt is raised.
- R7: While `busy_o` is 1, `supply_req_o` and `clk_req_o` are 1. Otherwise they equal `supply_req_i` and `clk_req_i`.
- R8: `stat_rd_i` or `irq_clr_i` high for a cycle clears `irq_o` at the next edge.
- R9: If an interrupt set and an interrupt clear fall on the same edge, the set wins.
- R10: The counter advances only on edges where `tick_i` is 1. With `tick_i` held at 0, a window never expires.
- R11: Dropping `mode_active_i` during a window stops the timer at the next edge. The status bits and `irq_o` are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_active_i | input | 1 | 1 while the device is in an active operating mode |
| tick_i | input | 1 | Single-cycle debounce clock enable |
| key_ni | input | NUM_KEYS | Raw active-low key inputs |
| stat_rd_i | input | 1 | Status register read strobe |
| irq_clr_i | input | 1 | Clear-interrupt command |
| supply_req_i | input | 1 | Supply-enable request from the register file |
| clk_req_i | input | 1 | Clock-enable request from the register file |
| status_o | output | NUM_KEYS | Debounced key state, 1 means pressed |
| irq_o | output | 1 | Interrupt flag |
| busy_o | output | 1 | Debounce timer running |
| supply_req_o | output | 1 | Supply-enable request, forced high while busy |
| clk_req_o | output | 1 | Clock-enable request, forced high while busy |

## Verification
A wrong owner register or a stuck count shows as a status update on the wrong bit, or as an interrupt arriving a different number of ticks after the last key change. The bench measures that edge count exactly for every key, so the error is visible within one window. A mishandled restart or abort shows as a shortened window, or as an interrupt where none should come. The bench watches for an extra WINDOW+5 cycles after each abort, mode drop and inactive press, so such an error is caught within one window length.

// File: rtl/kdb_pkg.sv
package kdb_pkg;
   // Classification of the key events seen in one cycle
   typedef enum logic [1:0] {
      EV_NONE    = 2'd0,
      EV_START   = 2'd1,
      EV_RESTART = 2'd2,
      EV_ABORT   = 2'd3
   } kdb_evt_e;
endpackage

// File: rtl/kdb_sync.sv
module kdb_sync #(
   parameter int NUM_KEYS = 4,
   parameter int STAGES   = 2
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [NUM_KEYS-1:0] key_ni,
   output logic [NUM_KEYS-1:0] lvl_o,
   output logic [NUM_KEYS-1:0] edge_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("kdb_sync: STAGES must be at least 2");
   end

   for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
      logic [STAGES-1:0] chain_q;
      logic              prev_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
         end else begin
            chain_q <= {chain_q[STAGES-2:0], key_ni[k]};
            prev_q  <= chain_q[STAGES-1];
         end
      end

      assign lvl_o[k]  = chain_q[STAGES-1];
      assign edge_o[k] = chain_q[STAGES-1] ^ prev_q;
   end
endmodule

// File: rtl/kdb_arbiter.sv
module kdb_arbiter
   import kdb_pkg::*;
#(
   parameter int NUM_KEYS = 4,
   parameter int IDX_W    = 2
) (
   input  logic [NUM_KEYS-1:0] edge_i,
   input  logic                active_i,
   input  logic                running_i,
   input  logic [IDX_W-1:0]    owner_i,
   output kdb_evt_e            kind_o,
   output logic [IDX_W-1:0]    pick_o
);
   logic [NUM_KEYS-1:0] foreign;

   for (genvar k = 0; k < NUM_KEYS; k++) begin : g_foreign
      assign foreign[k] = edge_i[k] && (owner_i != IDX_W'(k));
   end

   // lowest-numbered key wins when several change together
   always_comb begin
      pick_o = '0;
      for (int k = NUM_KEYS - 1; k >= 0; k--) begin
         if (edge_i[k]) pick_o = IDX_W'(k);
      end
   end

   always_comb begin
      if (!active_i || edge_i == '0) kind_o = EV_NONE;
      else if (!running_i)           kind_o = EV_START;
      else if (|foreign)             kind_o = EV_ABORT;
      else                           kind_o = EV_RESTART;
   end
endmodule

// File: rtl/kdb_timer.sv
module kdb_timer
   import kdb_pkg::*;
#(
   parameter int WINDOW = 8195,
   parameter int IDX_W  = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             active_i,
   input  logic             tick_i,
   input  kdb_evt_e         kind_i,
   input  logic [IDX_W-1:0] pick_i,
   output logic             running_o,
   output logic [IDX_W-1:0] owner_o,
   output logic             expire_o
);
   localparam int CNT_W = (WINDOW > 2) ? $clog2(WINDOW) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW - 1);

   if (WINDOW < 2) begin : g_bad_window
      $error("kdb_timer: WINDOW must be at least 2");
   end

   logic             run_q;
   logic [CNT_W-1:0] cnt_q;
   logic [IDX_W-1:0] own_q;

   assign expire_o  = run_q && active_i && (kind_i == EV_NONE) && tick_i && (cnt_q == LAST);
   assign running_o = run_q;
   assign owner_o   = own_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q <= 1'b0;
         cnt_q <= '0;
         own_q <= '0;
      end else if (!active_i) begin
         run_q <= 1'b0;
      end else begin
         unique case (kind_i)
            EV_START: begin
               run_q <= 1'b1;
               cnt_q <= '0;
               own_q <= pick_i;
            end
            EV_RESTART: cnt_q <= '0;
            EV_ABORT:   run_q <= 1'b0;
            default: begin
               if (run_q && tick_i) begin
                  if (cnt_q == LAST) run_q <= 1'b0;
                  else               cnt_q <= cnt_q + 1'b1;
               end
            end
         endcase
      end
   end

   AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_q |-> cnt_q <= LAST);                                             // R3
   AST_TICK_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_q && active_i && !tick_i && kind_i == EV_NONE) |=> (run_q && $stable(cnt_q))); // R10
   AST_MODE_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !active_i |=> !run_q);                                                // R11
   AST_ABORT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active_i && kind_i == EV_ABORT) |=> !run_q);                         // R6
   AST_RESTART_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active_i && kind_i == EV_RESTART) |=> (run_q && cnt_q == '0));       // R5
endmodule

// File: rtl/key_debouncer.sv
module key_debouncer
   import kdb_pkg::*;
#(
   parameter int NUM_KEYS    = 4,
   parameter int WINDOW      = 8195,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                mode_active_i,
   input  logic                tick_i,
   input  logic [NUM_KEYS-1:0] key_ni,
   input  logic                stat_rd_i,
   input  logic                irq_clr_i,
   input  logic                supply_req_i,
   input  logic                clk_req_i,
   output logic [NUM_KEYS-1:0] status_o,
   output logic                irq_o,
   output logic                busy_o,
   output logic                supply_req_o,
   output logic                clk_req_o
);
   localparam int IDX_W = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1;

   if (NUM_KEYS < 1) begin : g_bad_keys
      $error("key_debouncer: NUM_KEYS must be at least 1");
   end

   logic [NUM_KEYS-1:0] lvl, edges, status_q;
   logic [IDX_W-1:0]    owner, pick;
   logic                running, expire, irq_q;
   kdb_evt_e            kind;

   kdb_sync #(.NUM_KEYS(NUM_KEYS), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .key_ni(key_ni), .lvl_o(lvl), .edge_o(edges));

   kdb_arbiter #(.NUM_KEYS(NUM_KEYS), .IDX_W(IDX_W)) u_arb (
      .edge_i(edges), .active_i(mode_active_i), .running_i(running),
      .owner_i(owner), .kind_o(kind), .pick_o(pick));

   kdb_timer #(.WINDOW(WINDOW), .IDX_W(IDX_W)) u_timer (
      .clk_i(clk_i), .rst_ni(rst_ni), .active_i(mode_active_i), .tick_i(tick_i),
      .kind_i(kind), .pick_i(pick), .running_o(running), .owner_o(owner),
      .expire_o(expire));

   for (genvar k = 0; k < NUM_KEYS; k++) begin : g_stat
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                            status_q[k] <= 1'b0;
         else if (expire && owner == IDX_W'(k))  status_q[k] <= ~lvl[k];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      irq_q <= 1'b0;
      else if (expire)                  irq_q <= 1'b1;
      else if (stat_rd_i || irq_clr_i)  irq_q <= 1'b0;
   end

   assign status_o     = status_q;
   assign irq_o        = irq_q;
   assign busy_o       = running;
   assign supply_req_o = running | supply_req_i;
   assign clk_req_o    = running | clk_req_i;

   AST_STATUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !expire |=> $stable(status_q));                                       // R3
   AST_IRQ_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_q) |-> $past(expire));                                      // R3
   AST_IRQ_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((stat_rd_i || irq_clr_i) && !expire) |=> !irq_q);                    // R8
   AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire |=> (irq_q && !running));                                      // R9
   AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !mode_active_i |=> $stable(status_q) && !$rose(irq_q));               // R1
endmodule

// File: tb/key_debouncer_bench.sv
module key_debouncer_bench;
   localparam int NK = 4;
   localparam int W  = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          act = 1'b1, tick = 1'b1, rd = 1'b0, clr = 1'b0;
   logic          sreq = 1'b0, creq = 1'b0;
   logic [NK-1:0] keys = '1;
   logic [NK-1:0] st;
   logic          irq, busy, sreq_o, creq_o;
   logic [NK-1:0] exp_st = '0;
   int            vectors = 0, errs = 0, cyc = 0;

   always #4 clk = ~clk;

   key_debouncer #(.NUM_KEYS(NK), .WINDOW(W), .SYNC_STAGES(2)) u_key_debouncer (
      .clk_i(clk), .rst_ni(rst_n), .mode_active_i(act), .tick_i(tick), .key_ni(keys),
      .stat_rd_i(rd), .irq_clr_i(clr), .supply_req_i(sreq), .clk_req_i(creq),
      .status_o(st), .irq_o(irq), .busy_o(busy), .supply_req_o(sreq_o), .clk_req_o(creq_o));

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         errs = errs + 1;
         $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] a, input logic [31:0] e);
      vectors++;
      if (a !== e) begin
         errs++;
         $display("FAIL %s act=%0h exp=%0h", req, a, e);
      end
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // counts edges from now until irq is seen at a falling edge
   task automatic wait_irq(output int n);
      n = 0;
      do begin
         @(posedge clk);
         n++;
         @(negedge clk);
         if (n == 4 && !irq) begin
            chk("R7 supply forced", 32'(sreq_o), 32'd1);
            chk("R7 clock forced", 32'(creq_o), 32'd1);
         end
      end while (!irq && n < W + 40);
   endtask

   task automatic window(input int k, input logic lvl, input string req);
      int n;
      keys[k] = lvl;
      wait_irq(n);
      exp_st[k] = ~lvl;
      chk({req, " R2 edges to irq"}, n, W + 3);
      chk({req, " R3 irq set"}, 32'(irq), 32'd1);
      chk({req, " R3 busy off"}, 32'(busy), 32'd0);
      chk({req, " R4 status"}, 32'(st), 32'(exp_st));
   endtask

   task automatic clear_irq(input logic use_rd);
      if (use_rd) rd = 1'b1; else clr = 1'b1;
      @(negedge clk);
      rd = 1'b0; clr = 1'b0;
      chk(use_rd ? "R8 read clears" : "R8 command clears", 32'(irq), 32'd0);
   endtask

   initial begin
      int n;
      cycles(3);
      rst_n = 1'b1;
      cycles(2);
      chk("reset status", 32'(st), 32'd0);
      chk("reset irq", 32'(irq), 32'd0);
      chk("reset busy", 32'(busy), 32'd0);
      sreq = 1'b1; creq = 1'b0;
      @(negedge clk);
      chk("R7 idle supply follows", 32'(sreq_o), 32'd1);
      chk("R7 idle clock follows", 32'(creq_o), 32'd0);
      sreq = 1'b0;

      // sweep every key through press and release
      for (int k = 0; k < NK; k++) begin
         window(k, 1'b0, "press");
         clear_irq(1'b1);
         window(k, 1'b1, "release");
         clear_irq(1'b0);
      end

      // R5: bounce on the owning key restarts the window
      keys[2] = 1'b0; cycles(4);
      keys[2] = 1'b1; cycles(1);
      chk("R5 busy during bounce", 32'(busy), 32'd1);
      window(2, 1'b0, "R5 bounce");
      clear_irq(1'b1);
      window(2, 1'b1, "R5 settle");
      clear_irq(1'b1);

      // R6: another key aborts the window
      keys[0] = 1'b0; cycles(5);
      chk("R6 busy before abort", 32'(busy), 32'd1);
      keys[3] = 1'b0; cycles(3);
      chk("R6 busy after abort", 32'(busy), 32'd0);
      cycles(W + 5);
      chk("R6 no irq", 32'(irq), 32'd0);
      chk("R6 status unchanged", 32'(st), 32'(exp_st));
      window(3, 1'b1, "R6 cleanup");
      clear_irq(1'b0);
      window(0, 1'b1, "R6 cleanup");
      clear_irq(1'b0);

      // R10: no tick, no progress
      tick = 1'b0;
      keys[1] = 1'b0; cycles(23);
      chk("R10 busy held", 32'(busy), 32'd1);
      chk("R10 no expiry", 32'(irq), 32'd0);
      tick = 1'b1;
      n = 0;
      do begin @(posedge clk); n++; @(negedge clk); end while (!irq && n < W + 20);
      exp_st[1] = 1'b1;
      chk("R10 ticks to expiry", n, W);
      chk("R10 status", 32'(st), 32'(exp_st));
      clear_irq(1'b1);
      window(1, 1'b1, "R10 release");
      clear_irq(1'b1);

      // R1: inactive mode ignores keys
      act = 1'b0;
      keys[2] = 1'b0; cycles(W + 10);
      chk("R1 inactive busy", 32'(busy), 32'd0);
      chk("R1 inactive irq", 32'(irq), 32'd0);
      chk("R1 inactive status", 32'(st), 32'(exp_st));
      act = 1'b1; cycles(W + 10);
      chk("R1 no stale event", 32'(busy | irq), 32'd0);
      window(2, 1'b1, "R1 release");
      clear_irq(1'b0);

      // R11: leaving active mode mid-window
      keys[3] = 1'b0; cycles(5);
      act = 1'b0; cycles(1);
      chk("R11 stopped", 32'(busy), 32'd0);
      cycles(W + 5);
      chk("R11 irq kept", 32'(irq), 32'd0);
      chk("R11 status kept", 32'(st), 32'(exp_st));
      act = 1'b1;
      window(3, 1'b1, "R11 release");
      clear_irq(1'b1);

      // R9: set beats a clear held on the same edge
      clr = 1'b1;
      keys[0] = 1'b0;
      wait_irq(n);
      exp_st[0] = 1'b1;
      chk("R9 edges", n, W + 3);
      chk("R9 set wins", 32'(irq), 32'd1);
      @(negedge clk);
      chk("R8 clear after set", 32'(irq), 32'd0);
      clr = 1'b0;
      chk("R9 status", 32'(st), 32'(exp_st));

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
   end
endmodule